// File: doc/BRIEF.md
# Serial SAR converter readout controller

This block is the host-side master for a three-wire serial successive-approximation converter with a 14-bit two's-complement result. On a start request it holds the active-low chip select high for one full data-clock period, pulls it low and toggles a data clock derived from the system clock by a programmable half-period divider. It samples the converter's serial output on each rising data-clock edge. It skips the sampling window and the null bit, keeps the 14 result bits, ignores the two padding zeros, and then raises chip select.

The result comes out on a 14-bit bus with a one-cycle valid strobe. A busy flag covers the time from a request until its result is out. A request that arrives during a frame is held and served after that frame. A continuous mode runs frames back to back, with chip select high between them, so the converter powers down in each gap. The divider setting is clamped so that the data clock always meets the converter's frequency and phase-width limits at the configured system clock.

Top module: `sar_adc_reader`

## Requirements
- R1: After reset `cs_n_o` is 1, `dclk_o` is 0, `valid_o` is 0, `busy_o` is 0 and `data_o` is 0.
- R2: Before each frame `cs_n_o` is high for exactly two half periods (one data-clock period). `dclk_o` is 0 whenever `cs_n_o` is 1 and in the cycle where `cs_n_o` falls. The first `dclk_o` edge of a frame is a rising edge, one half period after the fall.
- R3: A data-clock half period lasts H system clocks, where H is `div_half_i` clamped to [MIN, MAX]. MIN is the larger of ceil(f_sys/(2*1.2 MHz)) and ceil(200 ns*f_sys). MAX is floor(f_sys/(2*24 kHz)). At 250 MHz these give MIN=105 and MAX=5208.
- R4: A frame has 22+min(`ext_clk_i`,2) rising data-clock edges. `cs_n_o` rises in the same cycle as the last falling edge.
- R5: `data_o` is the 14 bits sampled from `sdo_i` on rising edges 7 to 20 of the frame, first bit as MSB (bit 13). Edges 1 to 5 (sampling window), edge 6 (null bit) and edges 21 and later (padding) are not captured.
- R6: `valid_o` is high for exactly one cycle per frame, in the cycle where `dclk_o` shows its 20th rising edge, while `cs_n_o` is low. `data_o` holds its value until the next strobe.
- R7: `busy_o` = pending request OR (frame running AND result not yet strobed). It is high from the cycle after `start_i` until the cycle of `valid_o`.
- R8: A `start_i` pulse during a frame or gap is held and served by a new frame after the following chip-select gap. Several pulses before that frame starts merge into one frame.
- R9: While `cont_i` is 1, a new frame follows each gap without `start_i`. After `cont_i` drops, the frame in progress completes and no new frame starts.
- R10: `div_half_i` and `ext_clk_i` are latched only when a gap begins. Changing them during a frame leaves that frame's clock count and half period unchanged, and the new values take effect from the next gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_half_i | input | DIV_W | Requested data-clock half period in system clocks |
| ext_clk_i | input | EXT_W | Extra data clocks beyond 22 (clamped to N_EXTRA_MAX) |
| start_i | input | 1 | Single-shot conversion request pulse |
| cont_i | input | 1 | Continuous back-to-back conversion mode |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| dclk_o | output | 1 | Data clock to the converter |
| data_o | output | RES_W | Signed conversion result |
| valid_o | output | 1 | One-cycle result strobe |
| busy_o | output | 1 | Request outstanding |

## Verification
The hardest case to reach from the ports is a request arriving while a frame is already under way, together with divider and clock-count settings that change mid-frame. Only the latching point separates a correct design from one that reacts at once. The stimulus fires extra start pulses and rewrites `div_half_i` and `ext_clk_i` after chip select has fallen. It then counts rising edges per frame and measures the first half period of the next frame. The top divider clamp is reached by requesting a very long half period, timing the first rising edge, and cutting the frame short with reset.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_RUN  = 2'd2
  } rd_state_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sar_rd_clkdiv.sv
module sar_rd_clkdiv #(
  parameter int DIV_W    = 16,
  parameter int MIN_HALF = 105,
  parameter int MAX_HALF = 5208
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_half_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] HALF_LO = DIV_W'(MIN_HALF);
  localparam logic [DIV_W-1:0] HALF_HI = DIV_W'(MAX_HALF);

  logic [DIV_W-1:0] half_q, half_d, cnt_q;

  always_comb begin
    if (div_half_i < HALF_LO)      half_d = HALF_LO;
    else if (div_half_i > HALF_HI) half_d = HALF_HI;
    else                           half_d = div_half_i;
  end

  assign tick_o = run_i && (cnt_q == half_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= HALF_LO;
      cnt_q  <= '0;
    end else if (load_i) begin
      half_q <= half_d;
      cnt_q  <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  AST_HALF_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (div_half_i < HALF_LO) |=> half_q == HALF_LO); // R3
  AST_HALF_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (div_half_i > HALF_HI) |=> half_q == HALF_HI); // R3
  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && !load_i |=> !tick_o); // R3
endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
  import sar_rd_pkg::*;
#(
  parameter int RES_W       = 14,
  parameter int SAMPLE_CLKS = 5,
  parameter int NULL_BITS   = 1,
  parameter int PAD_BITS    = 2,
  parameter int N_EXTRA_MAX = 2,
  parameter int EXT_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic [EXT_W-1:0] ext_clk_i,
  input  logic             tick_i,
  output logic             load_o,
  output logic             run_o,
  output logic             cs_n_o,
  output logic             dclk_o,
  output logic             rise_o,
  output logic             cap_o,
  output logic             last_o,
  output logic             busy_o
);
  localparam int N_BASE    = SAMPLE_CLKS + NULL_BITS + RES_W + PAD_BITS;
  localparam int N_MAX     = N_BASE + N_EXTRA_MAX;
  localparam int HC_W      = $clog2(2 * N_MAX);
  localparam int NC_W      = $clog2(N_MAX + 1);
  localparam int CAP_FIRST = SAMPLE_CLKS + NULL_BITS + 1;
  localparam int CAP_LAST  = CAP_FIRST + RES_W - 1;
  localparam logic [HC_W-1:0] CAP_LO = HC_W'(2 * (CAP_FIRST - 1));
  localparam logic [HC_W-1:0] CAP_HI = HC_W'(2 * (CAP_LAST - 1));

  rd_state_e       st_q;
  logic [HC_W-1:0] hcnt_q, last_idx;
  logic [NC_W-1:0] nclk_q, nclk_d;
  logic            dclk_q, cs_q, pend_q, capd_q;
  logic            go, run_end, gap_end, start_run;

  always_comb begin
    if (int'(ext_clk_i) > N_EXTRA_MAX) nclk_d = NC_W'(N_MAX);
    else                               nclk_d = NC_W'(N_BASE + int'(ext_clk_i));
  end

  assign last_idx  = HC_W'(2 * int'(nclk_q) - 1);
  assign go        = pend_q | cont_i;
  assign run_end   = (st_q == ST_RUN) && tick_i && (hcnt_q == last_idx);
  assign gap_end   = (st_q == ST_GAP) && tick_i && (hcnt_q == HC_W'(1));
  assign start_run = gap_end && go;
  assign load_o    = ((st_q == ST_IDLE) && go) || run_end;
  assign run_o     = (st_q != ST_IDLE);
  // even half index = rising edge about to be shown
  assign rise_o    = (st_q == ST_RUN) && tick_i && !hcnt_q[0];
  assign cap_o     = (hcnt_q >= CAP_LO) && (hcnt_q <= CAP_HI);
  assign last_o    = rise_o && (hcnt_q == CAP_HI);
  assign cs_n_o    = cs_q;
  assign dclk_o    = dclk_q;
  assign busy_o    = pend_q | ((st_q == ST_RUN) & ~capd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      hcnt_q <= '0;
      nclk_q <= NC_W'(N_BASE);
      dclk_q <= 1'b0;
      cs_q   <= 1'b1;
      pend_q <= 1'b0;
      capd_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~start_run) | start_i;
      if (load_o) nclk_q <= nclk_d;
      if (start_run)   capd_q <= 1'b0;
      else if (last_o) capd_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (go) begin
            st_q   <= ST_GAP;
            hcnt_q <= '0;
          end
        end
        ST_GAP: begin
          if (gap_end) begin
            hcnt_q <= '0;
            if (go) begin
              st_q <= ST_RUN;
              cs_q <= 1'b0;
            end else begin
              st_q <= ST_IDLE;
            end
          end else if (tick_i) begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (tick_i) dclk_q <= ~dclk_q;
          if (run_end) begin
            st_q   <= ST_GAP;
            hcnt_q <= '0;
            cs_q   <= 1'b1;
          end else if (tick_i) begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_DCLK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> !dclk_q); // R2
  AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && (st_q == ST_RUN) |=> pend_q); // R8
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R7
  AST_CS_RISE_LOW_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_q) |-> $fell(dclk_q)); // R4
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture #(
  parameter int RES_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             cap_i,
  input  logic             last_i,
  input  logic             sdo_i,
  output logic [RES_W-1:0] data_o,
  output logic             valid_o
);
  logic [RES_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i && cap_i) sh_q <= {sh_q[RES_W-2:0], sdo_i};
      if (last_i) begin
        data_o  <= {sh_q[RES_W-2:0], sdo_i};
        valid_o <= 1'b1;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(data_o)); // R6
endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
  import sar_rd_pkg::*;
#(
  parameter int SYS_CLK_HZ   = 250_000_000,
  parameter int DCLK_MAX_HZ  = 1_200_000,
  parameter int DCLK_MIN_HZ  = 24_000,
  parameter int MIN_PHASE_NS = 200,
  parameter int DIV_W        = 16,
  parameter int RES_W        = 14,
  parameter int N_EXTRA_MAX  = 2,
  parameter int EXT_W        = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_half_i,
  input  logic [EXT_W-1:0] ext_clk_i,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             sdo_i,
  output logic             cs_n_o,
  output logic             dclk_o,
  output logic [RES_W-1:0] data_o,
  output logic             valid_o,
  output logic             busy_o
);
  localparam int HALF_FMAX  = ceil_div(SYS_CLK_HZ, 2 * DCLK_MAX_HZ);
  localparam int HALF_PHASE = ceil_div((SYS_CLK_HZ / 1000) * MIN_PHASE_NS, 1_000_000);
  localparam int MIN_HALF   = max_int(max_int(HALF_FMAX, HALF_PHASE), 2);
  localparam int MAX_HALF   = SYS_CLK_HZ / (2 * DCLK_MIN_HZ);

  logic tick, load, run, rise, cap, last;

  sar_rd_clkdiv #(
    .DIV_W   (DIV_W),
    .MIN_HALF(MIN_HALF),
    .MAX_HALF(MAX_HALF)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .run_i     (run),
    .div_half_i(div_half_i),
    .tick_o    (tick)
  );

  sar_rd_seq #(
    .RES_W      (RES_W),
    .N_EXTRA_MAX(N_EXTRA_MAX),
    .EXT_W      (EXT_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cont_i   (cont_i),
    .ext_clk_i(ext_clk_i),
    .tick_i   (tick),
    .load_o   (load),
    .run_o    (run),
    .cs_n_o   (cs_n_o),
    .dclk_o   (dclk_o),
    .rise_o   (rise),
    .cap_o    (cap),
    .last_o   (last),
    .busy_o   (busy_o)
  );

  sar_rd_capture #(
    .RES_W(RES_W)
  ) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .cap_i  (cap),
    .last_i (last),
    .sdo_i  (sdo_i),
    .data_o (data_o),
    .valid_o(valid_o)
  );

  AST_RESULT_BEFORE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !cs_n_o); // R6
  AST_CS_FALL_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> !dclk_o); // R2
  AST_CS_HIGH_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |=> cs_n_o); // R2
endmodule

// File: tb/tb_sar_adc_reader.sv
module tb_sar_adc_reader;
  localparam int MINH = 105;
  localparam int MAXH = 5208;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] div_half_i = '0;
  logic [1:0]  ext_clk_i = '0;
  logic        start_i = 1'b0;
  logic        cont_i = 1'b0;
  logic        sdo_i = 1'b1;
  logic        cs_n_o, dclk_o, valid_o, busy_o;
  logic [13:0] data_o;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sar_adc_reader dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_half_i(div_half_i), .ext_clk_i(ext_clk_i),
    .start_i(start_i), .cont_i(cont_i), .sdo_i(sdo_i), .cs_n_o(cs_n_o),
    .dclk_o(dclk_o), .data_o(data_o), .valid_o(valid_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // converter model
  logic [13:0] dev_q[$];
  logic [13:0] dev_cur = '0;
  int          fcnt = 0;
  always @(negedge cs_n_o) begin
    fcnt = 0;
    dev_cur = (dev_q.size() > 0) ? dev_q.pop_front() : 14'h0;
    sdo_i = 1'b1;
  end
  always @(posedge cs_n_o) sdo_i = 1'b1;
  always @(negedge dclk_o) begin
    if (cs_n_o === 1'b0) begin
      fcnt++;
      if (fcnt == 5 || fcnt == 20 || fcnt == 21) sdo_i = 1'b0;
      else if (fcnt >= 6 && fcnt <= 19) sdo_i = dev_cur[19-fcnt];
      else sdo_i = 1'b1;
    end
  end

  // reference model
  logic [13:0] exp_q[$];
  int m_mode = 0, m_t = 0, m_g = 0, m_h = MINH, m_n = 22;
  bit m_pend = 0, m_valid = 0;
  logic [13:0] m_data = '0, m_cur = '0;

  function automatic int clamp_h(input int d);
    return (d < MINH) ? MINH : (d > MAXH) ? MAXH : d;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_t = 0; m_g = 0; m_h = MINH; m_n = 22;
      m_pend = 0; m_valid = 0; m_data = '0;
    end else begin
      bit go, clr;
      go = m_pend || cont_i;
      clr = 0;
      m_valid = 0;
      if (m_mode == 0) begin
        if (go) begin
          m_mode = 1; m_g = 0;
          m_h = clamp_h(int'(div_half_i));
          m_n = 22 + ((ext_clk_i > 2) ? 2 : int'(ext_clk_i));
        end
      end else if (m_mode == 1) begin
        if (m_g == 2*m_h - 1) begin
          if (go) begin
            m_mode = 2; m_t = 0; clr = 1;
            m_cur = (exp_q.size() > 0) ? exp_q.pop_front() : 14'h0;
          end else m_mode = 0;
        end else m_g++;
      end else begin
        if (m_t == 2*m_n*m_h - 1) begin
          m_mode = 1; m_g = 0;
          m_h = clamp_h(int'(div_half_i));
          m_n = 22 + ((ext_clk_i > 2) ? 2 : int'(ext_clk_i));
        end else begin
          m_t++;
          if (m_t == 39*m_h) begin
            m_valid = 1; m_data = m_cur;
          end
        end
      end
      m_pend = (m_pend && !clr) || start_i;
    end
  end

  // per-cycle comparison and observers
  int vcount = 0, rc = 0, last_rc = 0;
  bit prev_dclk = 0, prev_cs = 1;
  logic [13:0] last_data = '0;
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      bit e_cs, e_dclk, e_busy;
      e_cs   = (m_mode != 2);
      e_dclk = (m_mode == 2) && (((m_t / m_h) % 2) == 1);
      e_busy = m_pend || (m_mode == 2 && m_t < 39*m_h);
      chk(cs_n_o === e_cs, "R4 cs_n_o", int'(cs_n_o), int'(e_cs));
      chk(dclk_o === e_dclk, "R3 dclk_o", int'(dclk_o), int'(e_dclk));
      chk(valid_o === m_valid, "R6 valid_o", int'(valid_o), int'(m_valid));
      chk(busy_o === e_busy, "R7 busy_o", int'(busy_o), int'(e_busy));
      chk(data_o === m_data, "R5 data_o", int'(data_o), int'(m_data));
      if (valid_o) begin vcount++; last_data = data_o; end
      if (dclk_o && !prev_dclk) rc++;
      if (cs_n_o && !prev_cs) begin last_rc = rc; rc = 0; end
    end
    prev_dclk = dclk_o;
    prev_cs = cs_n_o;
    if (cyc > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog R9 act=%0d exp=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask
  task automatic pulse_start();
    start_i = 1'b1; tick(1); start_i = 1'b0;
  endtask
  task automatic push(input logic [13:0] v);
    dev_q.push_back(v); exp_q.push_back(v);
  endtask
  task automatic first_half(output int n);
    @(negedge clk_i);
    while (cs_n_o !== 1'b0) @(negedge clk_i);
    n = 0;
    while (dclk_o !== 1'b1) begin @(negedge clk_i); n++; end
  endtask
  task automatic wait_idle();
    @(negedge clk_i);
    while (m_mode != 0 || m_pend) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    #1;
  endtask

  initial begin
    int n, base;
    tick(5);
    // R1 reset state (checked during reset)
    chk(cs_n_o === 1'b1, "R1 cs_n_o", int'(cs_n_o), 1);
    chk(dclk_o === 1'b0, "R1 dclk_o", int'(dclk_o), 0);
    chk(valid_o === 1'b0, "R1 valid_o", int'(valid_o), 0);
    chk(busy_o === 1'b0, "R1 busy_o", int'(busy_o), 0);
    chk(data_o === 14'h0, "R1 data_o", int'(data_o), 0);
    rst_ni = 1'b1;
    tick(4);

    // low clamp, basic frame
    push(14'h1ABC); div_half_i = 16'd0; ext_clk_i = 2'd0;
    pulse_start();
    first_half(n);
    chk(n == MINH, "R3 low clamp half", n, MINH);
    wait_idle();
    chk(last_rc == 22, "R4 rises base", last_rc, 22);
    chk(last_data == 14'h1ABC, "R5 data", int'(last_data), 'h1ABC);

    // extra clocks clamped, all ones
    push(14'h3FFF); div_half_i = 16'd110; ext_clk_i = 2'd3;
    pulse_start();
    first_half(n);
    chk(n == 110, "R3 mid half", n, 110);
    wait_idle();
    chk(last_rc == 24, "R4 rises ext clamp", last_rc, 24);
    chk(last_data == 14'h3FFF, "R5 data minus one", int'(last_data), 'h3FFF);

    // most negative code
    push(14'h2000); div_half_i = 16'd105; ext_clk_i = 2'd0;
    pulse_start();
    wait_idle();
    chk(last_data == 14'h2000, "R5 data most negative", int'(last_data), 'h2000);

    // R8 pending starts during a frame merge into one extra frame
    base = vcount;
    push(14'h0155); push(14'h2AAA);
    pulse_start();
    first_half(n);
    tick(1000); pulse_start(); tick(10); pulse_start();
    wait_idle();
    chk(vcount - base == 2, "R8 frames served", vcount - base, 2);
    chk(last_data == 14'h2AAA, "R8 second result", int'(last_data), 'h2AAA);

    // R10 mid-frame changes take effect next gap
    push(14'h0F0F); push(14'h3333);
    div_half_i = 16'd130; ext_clk_i = 2'd1;
    pulse_start();
    first_half(n);
    div_half_i = 16'd200; ext_clk_i = 2'd0;
    pulse_start();
    wait_idle();
    chk(n == 130, "R10 half latched", n, 130);
    chk(last_rc == 22, "R10 new ext on next frame", last_rc, 22);

    // R9 continuous mode
    base = vcount;
    push(14'h0001); push(14'h1FFF); push(14'h2001);
    div_half_i = 16'd105; cont_i = 1'b1;
    @(negedge clk_i);
    while (vcount - base < 3) @(negedge clk_i);
    #1 cont_i = 1'b0;
    wait_idle();
    chk(vcount - base == 3, "R9 continuous frames", vcount - base, 3);
    chk(last_data == 14'h2001, "R9 last result", int'(last_data), 'h2001);

    // high clamp, frame aborted by reset
    push(14'h0AAA); div_half_i = 16'd6000;
    pulse_start();
    first_half(n);
    chk(n == MAXH, "R3 high clamp half", n, MAXH);
    tick(1); rst_ni = 1'b0; tick(3);
    chk(cs_n_o === 1'b1 && dclk_o === 1'b0, "R1 reset mid-frame", int'({cs_n_o, dclk_o}), 2);
    rst_ni = 1'b1; tick(5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule